// File: doc/BRIEF.md
# Transaction-Layer Request Header Checker

The block looks at the header of every transaction-layer request that arrives from the link side and assigns it one of three outcomes. The request is accepted, it is rejected as malformed (dropped with no flow-control credit returned), or it is refused as an unsupported request. When a refused request is non-posted, the block asks the completer side to send back a completion with unsupported-request status. That request carries the requester ID and tag copied from the header.

Headers arrive as a four-dword bus with a valid/ready handshake. Dword 0 sits in bits [31:0] and dword 3 in bits [127:96]. A 3-dword header leaves dword 3 unused. Several limits and conditions are applied as the header is taken in: the payload size limit, the read-request size limit, 4 KB page crossing, the function power state, locked reads and link state. One cycle after the handshake the block produces a verdict, a credit-release strobe and, where needed, the completion request. Two sticky error bits (malformed, unsupported) record what has happened until software clears them.

Top module: `tlp_req_checker`

## Requirements
- R1: `hdr_ready` is high from the first clock edge after reset. Each header taken (valid and ready both high) gives exactly one `verdict_valid` pulse on the next cycle. `verdict` is then 00 accept, 01 malformed or 10 unsupported. Header fields: format in dword0[31:29] (bit 30 means data present, bit 29 means 4-dword header), type in dword0[28:24], length in dwords in dword0[9:0], where 0 means 1024.
- R2: A request carrying data whose length exceeds 32 << `cfg_max_payload` dwords is malformed. Size codes above 5 count as 5.
- R3: A memory read (type 00000 or 00001, no data) whose length exceeds 32 << `cfg_max_read` dwords is malformed. Codes above 5 count as 5.
- R4: For a memory request (type 00000 or 00001), if address bits [11:2] plus the length in dwords is greater than 1024, the request is malformed. The address is taken from dword 2 for a 3-dword header and from dword 3 for a 4-dword header.
- R5: When `cfg_pwr_state` is not 0, a memory request or an I/O request (type 00010) is unsupported. Other request types are not affected by power state.
- R6: A locked memory read (type 00001, no data) is always unsupported.
- R7: While `cfg_link_up` is low, every non-posted request is unsupported. Posted requests are memory writes (type 00000 with data) and messages (type 10xxx). They are not affected by the link state.
- R8: When a malformed condition and an unsupported condition hit the same header, the verdict is malformed and no completion is requested.
- R9: `credit_release` pulses together with every accept or unsupported verdict, and never with a malformed verdict.
- R10: For an unsupported non-posted request, `cpl_req` is high for one cycle with the verdict. `cpl_rid` carries dword1[31:16] and `cpl_tag` carries dword1[15:8].
- R11: `err_status` bit 0 (malformed) and bit 1 (unsupported) are set by the matching verdict. They stay set until a 1 is written to the same bit of `err_clr`; a set in the same cycle wins over a clear. `err_pulse` marks each new error for one cycle.
- R12: During and just after reset, `verdict_valid`, `credit_release`, `cpl_req`, `err_status` and `err_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be taken |
| hdr_data | input | 128 | Header dwords 0..3, dword 0 in the low bits |
| cfg_max_payload | input | 3 | Payload size code (128 B << code) |
| cfg_max_read | input | 3 | Read request size code (128 B << code) |
| cfg_pwr_state | input | 2 | Function power state, 0 means fully on |
| cfg_link_up | input | 1 | Link is up |
| err_clr | input | 2 | Write-one-to-clear for the error bits |
| verdict_valid | output | 1 | Verdict present |
| verdict | output | 2 | 00 accept, 01 malformed, 10 unsupported |
| credit_release | output | 1 | Return flow-control credit for this header |
| cpl_req | output | 1 | Send an unsupported-request completion |
| cpl_rid | output | 16 | Requester ID for the completion |
| cpl_tag | output | 8 | Tag for the completion |
| err_status | output | 2 | Sticky errors: bit 0 malformed, bit 1 unsupported |
| err_pulse | output | 2 | One-cycle new-error marks |

## Verification
Each size rule is driven with a header exactly at the limit and with one dword more. This separates a strict comparison from an inclusive one. It also covers length code 0 (1024 dwords) and a reserved size code. Page crossing is tried with headers that end exactly on a 4 KB boundary and one dword past it, in both 3- and 4-dword form. The unused dword 3 of a short header is filled with an address that would cross, which catches the wrong address dword being used. The power and link rules are applied to posted, non-posted, configuration and message types to show which types they reach. A header that fails several rules at once checks the priority order, and a clear issued in the same cycle as a new error checks that setting wins.

// File: rtl/tlp_chk_pkg.sv
package tlp_chk_pkg;
  localparam int LEN_W         = 10;
  localparam int CNT_W         = LEN_W + 1;
  localparam int RID_W         = 16;
  localparam int TAG_W         = 8;
  localparam int PAGE_LOG2     = 12;
  localparam int PAGE_DW_W     = PAGE_LOG2 - 2;
  localparam int BASE_DW_LOG2  = 5;
  localparam int SIZE_CODE_MAX = 5;

  typedef enum logic [1:0] {
    V_ACCEPT    = 2'b00,
    V_MALFORMED = 2'b01,
    V_UNSUPP    = 2'b10
  } verdict_e;

  typedef struct packed {
    logic                 has_data;
    logic                 four_dw;
    logic                 is_mem;
    logic                 is_io;
    logic                 is_lock;
    logic                 is_posted;
    logic [CNT_W-1:0]     len_dw;
    logic [PAGE_DW_W-1:0] page_off;
    logic [RID_W-1:0]     rid;
    logic [TAG_W-1:0]     tag;
  } hdr_info_t;

  // Length field to dword count; the zero code stands for the largest size.
  function automatic logic [CNT_W-1:0] decode_len(input logic [LEN_W-1:0] f);
    return (f == '0) ? (CNT_W'(1) << LEN_W) : CNT_W'(f);
  endfunction

  // Size code to a dword limit; reserved codes saturate at the top code.
  function automatic logic [CNT_W-1:0] size_limit_dw(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'(SIZE_CODE_MAX)) ? 3'(SIZE_CODE_MAX) : code;
    return CNT_W'(1) << (BASE_DW_LOG2 + int'(c));
  endfunction

  // True when the transfer runs past the end of its page.
  function automatic logic crosses_page(input logic [PAGE_DW_W-1:0] off,
                                        input logic [CNT_W-1:0] n);
    logic [CNT_W:0] last_excl;
    last_excl = (CNT_W+1)'(off) + (CNT_W+1)'(n);
    return last_excl > ((CNT_W+1)'(1) << PAGE_DW_W);
  endfunction
endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
  import tlp_chk_pkg::*;
#(
  parameter int HDR_DW = 4,
  parameter int DW_W   = 32
) (
  input  logic [HDR_DW*DW_W-1:0] hdr,
  output hdr_info_t              info
);
  logic [DW_W-1:0] dw0, dw1, dw2, dw3;
  logic [2:0]      fmt;
  logic [4:0]      typ;
  logic [DW_W-1:0] addr_lo;

  assign dw0 = hdr[0*DW_W +: DW_W];
  assign dw1 = hdr[1*DW_W +: DW_W];
  assign dw2 = hdr[2*DW_W +: DW_W];
  assign dw3 = hdr[3*DW_W +: DW_W];
  assign fmt = dw0[31:29];
  assign typ = dw0[28:24];

  // Short headers hold the address in dword 2, long ones put the low half in dword 3.
  assign addr_lo = fmt[0] ? dw3 : dw2;

  always_comb begin
    info.has_data  = fmt[1];
    info.four_dw   = fmt[0];
    info.is_mem    = (typ[4:1] == 4'b0000);
    info.is_io     = (typ == 5'b00010);
    info.is_lock   = (typ == 5'b00001) && !fmt[1];
    info.is_posted = ((typ == 5'b00000) && fmt[1]) || (typ[4:3] == 2'b10);
    info.len_dw    = decode_len(dw0[LEN_W-1:0]);
    info.page_off  = addr_lo[PAGE_LOG2-1:2];
    info.rid       = dw1[31:16];
    info.tag       = dw1[15:8];
  end
endmodule

// File: rtl/tlp_rule_check.sv
module tlp_rule_check
  import tlp_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hdr_info_t info,
  input  logic [2:0] cfg_max_payload,
  input  logic [2:0] cfg_max_read,
  input  logic [1:0] cfg_pwr_state,
  input  logic      cfg_link_up,
  output verdict_e  verdict,
  output logic      need_cpl
);
  logic oversize_payload, oversize_read, page_cross;
  logic pwr_reject, lock_reject, link_reject;
  logic malformed_hit, unsupp_hit;

  assign oversize_payload = info.has_data && (info.len_dw > size_limit_dw(cfg_max_payload));
  assign oversize_read    = info.is_mem && !info.has_data &&
                            (info.len_dw > size_limit_dw(cfg_max_read));
  assign page_cross       = info.is_mem && crosses_page(info.page_off, info.len_dw);

  assign pwr_reject  = (cfg_pwr_state != 2'd0) && (info.is_mem || info.is_io);
  assign lock_reject = info.is_lock;
  assign link_reject = !cfg_link_up && !info.is_posted;

  assign malformed_hit = oversize_payload || oversize_read || page_cross;
  assign unsupp_hit    = pwr_reject || lock_reject || link_reject;

  always_comb begin
    if (malformed_hit)   verdict = V_MALFORMED;
    else if (unsupp_hit) verdict = V_UNSUPP;
    else                 verdict = V_ACCEPT;
  end

  assign need_cpl = (verdict == V_UNSUPP) && !info.is_posted;

  p_mal_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (malformed_hit && unsupp_hit) |-> (verdict == V_MALFORMED && !need_cpl));
  p_link_down_ur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_reject && !malformed_hit) |-> (verdict == V_UNSUPP && need_cpl));
  p_lock_ur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_reject && !malformed_hit) |-> need_cpl);
endmodule

// File: rtl/tlp_err_status.sv
module tlp_err_status #(
  parameter int ERR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set,
  input  logic [ERR_W-1:0] clr,
  output logic [ERR_W-1:0] status,
  output logic [ERR_W-1:0] pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      pulse  <= '0;
    end else begin
      status <= (status & ~clr) | set;
      pulse  <= set;
    end
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_bit
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr[i]) |=> status[i]);
    p_pulse_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> status[i]);
  end
endmodule

// File: rtl/tlp_req_checker.sv
module tlp_req_checker
  import tlp_chk_pkg::*;
#(
  parameter int HDR_DW = 4,
  parameter int DW_W   = 32,
  parameter int ERR_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  output logic                   hdr_ready,
  input  logic [HDR_DW*DW_W-1:0] hdr_data,
  input  logic [2:0]             cfg_max_payload,
  input  logic [2:0]             cfg_max_read,
  input  logic [1:0]             cfg_pwr_state,
  input  logic                   cfg_link_up,
  input  logic [ERR_W-1:0]       err_clr,
  output logic                   verdict_valid,
  output logic [1:0]             verdict,
  output logic                   credit_release,
  output logic                   cpl_req,
  output logic [RID_W-1:0]       cpl_rid,
  output logic [TAG_W-1:0]       cpl_tag,
  output logic [ERR_W-1:0]       err_status,
  output logic [ERR_W-1:0]       err_pulse
);
  hdr_info_t          info;
  verdict_e           rule_verdict;
  logic               rule_cpl;
  logic               take;
  logic [ERR_W-1:0]   err_set;

  tlp_hdr_decode #(.HDR_DW(HDR_DW), .DW_W(DW_W)) u_dec (
    .hdr  (hdr_data),
    .info (info)
  );

  tlp_rule_check u_rules (
    .clk             (clk),
    .rst_n           (rst_n),
    .info            (info),
    .cfg_max_payload (cfg_max_payload),
    .cfg_max_read    (cfg_max_read),
    .cfg_pwr_state   (cfg_pwr_state),
    .cfg_link_up     (cfg_link_up),
    .verdict         (rule_verdict),
    .need_cpl        (rule_cpl)
  );

  assign take = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) hdr_ready <= 1'b0;
    else        hdr_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict        <= V_ACCEPT;
      credit_release <= 1'b0;
      cpl_req        <= 1'b0;
      cpl_rid        <= '0;
      cpl_tag        <= '0;
    end else begin
      verdict_valid  <= take;
      credit_release <= take && (rule_verdict != V_MALFORMED);
      cpl_req        <= take && rule_cpl;
      if (take) verdict <= rule_verdict;
      if (take && rule_cpl) begin
        cpl_rid <= info.rid;
        cpl_tag <= info.tag;
      end
    end
  end

  always_comb begin
    err_set = '0;
    if (take) begin
      err_set[0] = (rule_verdict == V_MALFORMED);
      err_set[1] = (rule_verdict == V_UNSUPP);
    end
  end

  tlp_err_status #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (err_set),
    .clr    (err_clr),
    .status (err_status),
    .pulse  (err_pulse)
  );

  p_verdict_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> verdict_valid);
  p_no_spurious_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !verdict_valid);
  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (verdict != 2'b11));
  p_no_credit_malformed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict == V_MALFORMED) |-> !credit_release);
  p_credit_otherwise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict != V_MALFORMED) |-> credit_release);
  p_cpl_only_ur_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_req |-> (verdict_valid && verdict == V_UNSUPP));
  p_err_matches_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (err_pulse == {verdict == V_UNSUPP, verdict == V_MALFORMED}));
endmodule

// File: tb/tlp_req_checker_test.sv
module tlp_req_checker_test;
  localparam int N_VEC = 21;
  localparam int WDOG  = 20000;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [4:0]  typ;
    logic [9:0]  len;
    logic [31:0] addr;
    logic [2:0]  mps;
    logic [2:0]  mrrs;
    logic [1:0]  pwr;
    logic        link;
    logic [1:0]  exp_v;
    logic        exp_cpl;
    logic [3:0]  req;
  } vec_t;

  // fmt typ len addr mps mrrs pwr link verdict cpl req
  localparam vec_t VEC [0:N_VEC-1] = '{
    '{3'b000, 5'h00, 10'd16,  32'h0000_1000, 3'd1, 3'd2, 2'd0, 1'b1, 2'b00, 1'b0, 4'd1},  // R1 plain read
    '{3'b010, 5'h00, 10'd32,  32'h0000_2000, 3'd0, 3'd2, 2'd0, 1'b1, 2'b00, 1'b0, 4'd2},  // R2 at limit
    '{3'b010, 5'h00, 10'd33,  32'h0000_2000, 3'd0, 3'd2, 2'd0, 1'b1, 2'b01, 1'b0, 4'd2},  // R2 one over
    '{3'b010, 5'h00, 10'd0,   32'h0000_0000, 3'd5, 3'd5, 2'd0, 1'b1, 2'b00, 1'b0, 4'd2},  // R2 len 0 = 1024
    '{3'b000, 5'h00, 10'd128, 32'h0000_3000, 3'd5, 3'd2, 2'd0, 1'b1, 2'b00, 1'b0, 4'd3},  // R3 at limit
    '{3'b000, 5'h00, 10'd129, 32'h0000_3000, 3'd5, 3'd2, 2'd0, 1'b1, 2'b01, 1'b0, 4'd3},  // R3 one over
    '{3'b000, 5'h00, 10'd4,   32'h0000_0FF0, 3'd5, 3'd5, 2'd0, 1'b1, 2'b00, 1'b0, 4'd4},  // R4 ends on page
    '{3'b000, 5'h00, 10'd5,   32'h0000_0FF0, 3'd5, 3'd5, 2'd0, 1'b1, 2'b01, 1'b0, 4'd4},  // R4 crosses
    '{3'b010, 5'h00, 10'd2,   32'h0000_1FFC, 3'd5, 3'd5, 2'd0, 1'b1, 2'b01, 1'b0, 4'd4},  // R4 write crosses
    '{3'b000, 5'h00, 10'd8,   32'h0000_0100, 3'd5, 3'd5, 2'd3, 1'b1, 2'b10, 1'b1, 4'd5},  // R5 read in D3
    '{3'b010, 5'h00, 10'd8,   32'h0000_0100, 3'd5, 3'd5, 2'd2, 1'b1, 2'b10, 1'b0, 4'd5},  // R5 posted write
    '{3'b000, 5'h02, 10'd1,   32'h0000_0100, 3'd5, 3'd5, 2'd1, 1'b1, 2'b10, 1'b1, 4'd5},  // R5 io read
    '{3'b000, 5'h04, 10'd1,   32'h0000_0000, 3'd5, 3'd5, 2'd1, 1'b1, 2'b00, 1'b0, 4'd5},  // R5 cfg unaffected
    '{3'b000, 5'h01, 10'd4,   32'h0000_0100, 3'd5, 3'd5, 2'd0, 1'b1, 2'b10, 1'b1, 4'd6},  // R6 locked read
    '{3'b000, 5'h00, 10'd4,   32'h0000_0100, 3'd5, 3'd5, 2'd0, 1'b0, 2'b10, 1'b1, 4'd7},  // R7 read, link down
    '{3'b010, 5'h00, 10'd4,   32'h0000_0100, 3'd5, 3'd5, 2'd0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 write, link down
    '{3'b001, 5'h10, 10'd0,   32'h0000_0000, 3'd5, 3'd5, 2'd0, 1'b0, 2'b00, 1'b0, 4'd7},  // R7 message, link down
    '{3'b000, 5'h00, 10'd200, 32'h0000_0100, 3'd5, 3'd2, 2'd3, 1'b0, 2'b01, 1'b0, 4'd8},  // R8 all fail
    '{3'b011, 5'h00, 10'd64,  32'h0000_0F00, 3'd1, 3'd5, 2'd0, 1'b1, 2'b00, 1'b0, 4'd4},  // R4 long hdr ok
    '{3'b011, 5'h00, 10'd65,  32'h0000_0F00, 3'd5, 3'd5, 2'd0, 1'b1, 2'b01, 1'b0, 4'd4},  // R4 long hdr cross
    '{3'b000, 5'h00, 10'd0,   32'h0000_0000, 3'd5, 3'd7, 2'd0, 1'b1, 2'b00, 1'b0, 4'd3}   // R3 reserved code
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hdr_valid = 1'b0;
  logic         hdr_ready;
  logic [127:0] hdr_data = '0;
  logic [2:0]   cfg_max_payload = 3'd5;
  logic [2:0]   cfg_max_read = 3'd5;
  logic [1:0]   cfg_pwr_state = 2'd0;
  logic         cfg_link_up = 1'b1;
  logic [1:0]   err_clr = 2'b00;
  logic         verdict_valid;
  logic [1:0]   verdict;
  logic         credit_release;
  logic         cpl_req;
  logic [15:0]  cpl_rid;
  logic [7:0]   cpl_tag;
  logic [1:0]   err_status;
  logic [1:0]   err_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlp_req_checker uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .cfg_max_payload(cfg_max_payload), .cfg_max_read(cfg_max_read),
    .cfg_pwr_state(cfg_pwr_state), .cfg_link_up(cfg_link_up), .err_clr(err_clr),
    .verdict_valid(verdict_valid), .verdict(verdict), .credit_release(credit_release),
    .cpl_req(cpl_req), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
    .err_status(err_status), .err_pulse(err_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Drives one header for one handshake, then leaves the bench at the sampling negedge.
  task automatic send(input vec_t v, input logic [15:0] rid, input logic [7:0] tag);
    logic [31:0] d2, d3;
    if (v.fmt[0]) begin d2 = 32'h0000_0001; d3 = v.addr; end
    else begin d2 = v.addr; d3 = 32'h0000_0FFC; end
    @(negedge clk);
    hdr_data        = {d3, d2, {rid, tag, 8'hFF}, {v.fmt, v.typ, 14'd0, v.len}};
    cfg_max_payload = v.mps;
    cfg_max_read    = v.mrrs;
    cfg_pwr_state   = v.pwr;
    cfg_link_up     = v.link;
    hdr_valid       = 1'b1;
    @(negedge clk);
    hdr_valid       = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 values held during reset
    chk("R12 verdict_valid in reset", 32'(verdict_valid), 0);
    chk("R12 err_status in reset", 32'(err_status), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 verdict_valid after reset", 32'(verdict_valid), 0);
    chk("R12 credit_release after reset", 32'(credit_release), 0);
    chk("R12 cpl_req after reset", 32'(cpl_req), 0);
    chk("R12 err_pulse after reset", 32'(err_pulse), 0);
    chk("R1 hdr_ready after reset", 32'(hdr_ready), 1);

    for (int i = 0; i < N_VEC; i++) begin
      logic [15:0] rid;
      logic [7:0]  tag;
      string       tg;
      rid = 16'hA000 + 16'(i);
      tag = 8'h40 + 8'(i);
      tg  = $sformatf("R%0d vec %0d", VEC[i].req, i);
      send(VEC[i], rid, tag);
      chk({tg, " verdict_valid"}, 32'(verdict_valid), 1);
      chk({tg, " verdict"}, 32'(verdict), 32'(VEC[i].exp_v));
      chk({tg, " R9 credit"}, 32'(credit_release), 32'(VEC[i].exp_v != 2'b01));
      chk({tg, " R10 cpl_req"}, 32'(cpl_req), 32'(VEC[i].exp_cpl));
      chk({tg, " R11 err_pulse"}, 32'(err_pulse),
          32'({VEC[i].exp_v == 2'b10, VEC[i].exp_v == 2'b01}));
      if (VEC[i].exp_cpl) begin
        chk({tg, " R10 cpl_rid"}, 32'(cpl_rid), 32'(rid));
        chk({tg, " R10 cpl_tag"}, 32'(cpl_tag), 32'(tag));
      end
    end

    // R1 idle cycle gives no verdict; R10 completion request lasts one cycle
    send(VEC[13], 16'h1234, 8'h9A);
    chk("R10 cpl_req raised", 32'(cpl_req), 1);
    chk("R10 cpl_rid", 32'(cpl_rid), 32'h1234);
    @(negedge clk);
    chk("R10 cpl_req one cycle", 32'(cpl_req), 0);
    chk("R1 no verdict when idle", 32'(verdict_valid), 0);
    chk("R11 err_pulse one cycle", 32'(err_pulse), 0);

    // R11 sticky bits and write-one-to-clear
    chk("R11 both errors sticky", 32'(err_status), 3);
    err_clr = 2'b01;
    @(negedge clk);
    err_clr = 2'b00;
    chk("R11 clear malformed only", 32'(err_status), 2);
    @(negedge clk);
    chk("R11 unsupported still held", 32'(err_status), 2);
    err_clr = 2'b10;
    @(negedge clk);
    err_clr = 2'b00;
    chk("R11 clear unsupported", 32'(err_status), 0);

    // R11 set beats a clear in the same cycle
    @(negedge clk);
    hdr_data        = {32'h0, 32'h0000_2000, 32'hBEEF_11FF, {3'b010, 5'h00, 14'd0, 10'd33}};
    cfg_max_payload = 3'd0;
    cfg_link_up     = 1'b1;
    cfg_pwr_state   = 2'd0;
    hdr_valid       = 1'b1;
    err_clr         = 2'b01;
    @(negedge clk);
    hdr_valid = 1'b0;
    err_clr   = 2'b00;
    chk("R11 set wins over clear", 32'(err_status), 1);
    chk("R9 malformed gives no credit", 32'(credit_release), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule